// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

An eight-pin general-purpose I/O port controlled over a small register bus. Software writes an output value into a data latch and picks, pin by pin, whether each pin drives that value or floats as an input. A third, read-only view returns one word that mixes the two. Bits set as outputs show what the latch holds. Bits set as inputs show the synchronised level present on the pin.

Two standby inputs change how state is kept. Hardware standby clears the latch and the direction register in the same way a reset does. Software standby freezes every flop, so the latch, the direction register and the port view all keep their values while it lasts. A per-pin LCD-mode flag hands a pin to an external LCD driver. Such a pin is never driven by this block, and its bit in the port view reads as zero.

Top module: `gpio_port`

## Requirements
- R1: After the asynchronous reset (rst_ni low), the data latch and the direction register read 0x00, pin_o is 0x00 and pin_oe_o is 0x00.
- R2: A write strobe with address 0 (data latch) stores wdata_i at the next rising clock edge. A read at address 0 then returns that value.
- R3: Address 1 is the direction register (1 = output, 0 = input). It can be written and read back. pin_oe_o[i] equals direction[i] AND NOT lcd_mode_i[i].
- R4: pin_o always carries the data latch contents.
- R5: A read at address 2 (port view) returns, for each bit, the latch bit when the direction bit is 1 and the synchronised pin level when it is 0. A pin change shows up in the port view after two rising clock edges, and not after one.
- R6: A pin whose lcd_mode_i bit is 1 reads as 0 in the port view and has its output enable at 0.
- R7: A write to address 2 changes neither the data latch nor the direction register.
- R8: While hw_stby_i is high, each rising edge clears the data latch and the direction register to 0x00, and bus writes are ignored.
- R9: While sw_stby_i is high and hw_stby_i is low, the data latch, the direction register and the input synchroniser hold their values. Bus writes and pin changes have no effect, so the port view does not change.
- R10: rdata_o is 0x00 when rd_i is low, and also on a read of the unused address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_stby_i | input | 1 | Hardware standby: clears state |
| sw_stby_i | input | 1 | Software standby: freezes state |
| addr_i | input | 2 | Register select: 0 data, 1 direction, 2 port view, 3 unused |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| lcd_mode_i | input | 8 | Per-pin flag: pin taken by the LCD driver |
| pin_i | input | 8 | Pin levels, asynchronous |
| pin_o | output | 8 | Pin output values |
| pin_oe_o | output | 8 | Pin output enables, 1 = drive |

## Verification
Software standby is the hardest case to provoke. The bench must first load a known mix of latch, direction and synchronised pin values. It then raises sw_stby_i and, during the freeze, issues bus writes and flips the input pins. After several cycles it reads the port view back and confirms it still shows the old pin levels. It then releases standby and confirms that the new levels show up exactly two edges later. Hardware standby is handled the same way: the bench issues a write in the same cycle the clear happens.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PORT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_stby_i,
  input  logic             sw_stby_i,
  input  logic             wr_data_i,
  input  logic             wr_dir_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] dir_o
);
  logic [WIDTH-1:0] data_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (hw_stby_i) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (!sw_stby_i) begin
      if (wr_data_i) data_q <= wdata_i;
      if (wr_dir_i)  dir_q  <= wdata_i;
    end
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_stby_i,
  input  logic             sw_stby_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = pin_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         stage_q[s] <= '0;
      else if (hw_stby_i)  stage_q[s] <= '0;
      else if (!sw_stby_i) stage_q[s] <= stage_d;
    end
  end

  assign pin_sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  data_i,
  input  logic [WIDTH-1:0]  dir_i,
  input  logic [WIDTH-1:0]  pin_sync_i,
  input  logic [WIDTH-1:0]  lcd_mode_i,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] port_view;

  // LCD-owned pins read back as 0
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign port_view[i] = ~lcd_mode_i[i] & (dir_i[i] ? data_i[i] : pin_sync_i[i]);
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (reg_sel_e'(addr_i))
        SEL_DATA: rdata_o = data_i;
        SEL_DIR:  rdata_o = dir_i;
        SEL_PORT: rdata_o = port_view;
        SEL_NONE: rdata_o = '0;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_stby_i,
  input  logic              sw_stby_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  lcd_mode_i,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o
);
  logic             wr_data, wr_dir;
  logic [WIDTH-1:0] data_q, dir_q, pin_sync;

  // port view address has no write decode
  assign wr_data = wr_i && (reg_sel_e'(addr_i) == SEL_DATA);
  assign wr_dir  = wr_i && (reg_sel_e'(addr_i) == SEL_DIR);

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_stby_i (hw_stby_i),
    .sw_stby_i (sw_stby_i),
    .wr_data_i (wr_data),
    .wr_dir_i  (wr_dir),
    .wdata_i   (wdata_i),
    .data_o    (data_q),
    .dir_o     (dir_q)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_stby_i  (hw_stby_i),
    .sw_stby_i  (sw_stby_i),
    .pin_i      (pin_i),
    .pin_sync_o (pin_sync)
  );

  gpio_port_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .rd_i       (rd_i),
    .addr_i     (addr_i),
    .data_i     (data_q),
    .dir_i      (dir_q),
    .pin_sync_i (pin_sync),
    .lcd_mode_i (lcd_mode_i),
    .rdata_o    (rdata_o)
  );

  assign pin_o    = data_q;
  assign pin_oe_o = dir_q & ~lcd_mode_i;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hw_stby_i,
  input logic             sw_stby_i,
  input logic [1:0]       addr_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic [WIDTH-1:0] lcd_mode_i,
  input logic [WIDTH-1:0] pin_o,
  input logic [WIDTH-1:0] pin_oe_o
);
  assert_data_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd0 && !hw_stby_i && !sw_stby_i) |=> (pin_o == $past(wdata_i)));

  assert_lcd_no_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_oe_o & lcd_mode_i) == '0));

  assert_port_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd2 && !hw_stby_i) |=> $stable(pin_o));

  assert_hw_stby_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |=> (pin_o == '0 && pin_oe_o == '0));

  assert_sw_stby_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_stby_i && !hw_stby_i) |=> $stable(pin_o));

  assert_idle_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hw_stby_i  (hw_stby_i),
  .sw_stby_i  (sw_stby_i),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .lcd_mode_i (lcd_mode_i),
  .pin_o      (pin_o),
  .pin_oe_o   (pin_oe_o)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hw_stby_i = 1'b0, sw_stby_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0, lcd_mode_i = '0, pin_i = '0;
  logic [7:0] rdata_o, pin_o, pin_oe_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  gpio_port uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hw_stby_i(hw_stby_i), .sw_stby_i(sw_stby_i),
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .lcd_mode_i(lcd_mode_i), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    rd_i = 1'b0;
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [7:0] port_exp(logic [7:0] dir, logic [7:0] dat,
                                          logic [7:0] pin, logic [7:0] lcd);
    return ((dir & dat) | (~dir & pin)) & ~lcd;
  endfunction

  initial begin
    logic [7:0] r, held;
    cycles(2);
    rst_ni = 1'b1;
    cycles(1);
    // R1
    check("R1 pin_o", pin_o, 8'h00);
    check("R1 pin_oe_o", pin_oe_o, 8'h00);
    bus_read(2'd0, r); check("R1 data", r, 8'h00);
    bus_read(2'd1, r); check("R1 dir", r, 8'h00);
    // R5 port reflects pins after reset
    pin_i = 8'hA5; cycles(2);
    bus_read(2'd2, r); check("R5 port after reset", r, 8'hA5);
    // R10
    rd_i = 1'b0; addr_i = 2'd0; #1 check("R10 idle read", rdata_o, 8'h00);
    bus_write(2'd0, 8'h77);
    bus_read(2'd3, r); check("R10 unused addr", r, 8'h00);

    // R2 / R4 data sweep
    for (int v = 0; v < 256; v++) begin
      bus_write(2'd0, 8'(v));
      check("R4 pin_o", pin_o, 8'(v));
      bus_read(2'd0, r); check("R2 data readback", r, 8'(v));
    end

    // R3 direction sweep
    for (int v = 0; v < 256; v++) begin
      bus_write(2'd1, 8'(v));
      bus_read(2'd1, r); check("R3 dir readback", r, 8'(v));
      check("R3 oe", pin_oe_o, 8'(v));
    end

    // R5 / R6 port view sweep
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d, dt, p, l;
      d  = 8'(i);
      dt = 8'(i * 37) ^ 8'h3C;
      p  = ~8'(i * 11);
      l  = (i % 4 == 0) ? (8'h01 << (i / 4 % 8)) : 8'h00;
      lcd_mode_i = l;
      pin_i = p;
      bus_write(2'd1, d);
      bus_write(2'd0, dt);
      cycles(1);
      bus_read(2'd2, r); check("R5 port view", r, port_exp(d, dt, p, l));
      check("R6 oe", pin_oe_o, d & ~l);
    end
    lcd_mode_i = 8'h00;

    // R5 latency
    bus_write(2'd1, 8'h00);
    pin_i = 8'h00; cycles(3);
    pin_i = 8'hFF;
    cycles(1); bus_read(2'd2, r); check("R5 one edge", r, 8'h00);
    cycles(1); bus_read(2'd2, r); check("R5 two edges", r, 8'hFF);

    // R7
    bus_write(2'd0, 8'h96);
    bus_write(2'd1, 8'h3C);
    bus_write(2'd2, 8'hFF);
    bus_read(2'd0, r); check("R7 data", r, 8'h96);
    bus_read(2'd1, r); check("R7 dir", r, 8'h3C);
    check("R7 pin_o", pin_o, 8'h96);

    // R8
    bus_write(2'd0, 8'h5A);
    bus_write(2'd1, 8'hF0);
    @(negedge clk_i);
    hw_stby_i = 1'b1; addr_i = 2'd0; wdata_i = 8'h33; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    check("R8 pin_o", pin_o, 8'h00);
    check("R8 oe", pin_oe_o, 8'h00);
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, r); check("R8 dir write ignored", r, 8'h00);
    hw_stby_i = 1'b0;
    bus_read(2'd0, r); check("R8 data", r, 8'h00);

    // R9
    bus_write(2'd0, 8'hC3);
    bus_write(2'd1, 8'h0F);
    pin_i = 8'h55; cycles(2);
    bus_read(2'd2, r); held = r;
    check("R9 pre-standby view", r, port_exp(8'h0F, 8'hC3, 8'h55, 8'h00));
    sw_stby_i = 1'b1;
    pin_i = 8'hAA;
    bus_write(2'd0, 8'hFF);
    bus_write(2'd1, 8'hFF);
    cycles(3);
    check("R9 pin_o", pin_o, 8'hC3);
    bus_read(2'd0, r); check("R9 data", r, 8'hC3);
    bus_read(2'd1, r); check("R9 dir", r, 8'h0F);
    bus_read(2'd2, r); check("R9 port held", r, held);
    sw_stby_i = 1'b0;
    cycles(2);
    bus_read(2'd2, r); check("R9 port after release", r, port_exp(8'h0F, 8'hC3, 8'hAA, 8'h00));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule